// File: doc/BRIEF.md
# FIFO Retransmit Controller

This block sits in the read-clock domain of a synchronous FIFO and adds a replay feature: data that has already been read can be read again, starting from the first memory location. A retransmit request is signalled by a falling level on the active-low request input. When the request is legal, the controller runs a fixed-length setup phase. During setup it pulses a read-pointer reload, forces the empty flag low and marks the almost-empty and almost-full flags as invalid. It then releases the empty flag, and reads restart from location zero. Each replayed word, including the first, needs its own active-low read enable on a read-clock edge.

Legality depends on the latency mode. In normal-latency mode both the read enable and the write enable must be idle (high) when the request is sampled. In zero-latency mode only the write enable must be idle. In both modes the number of words read since reset must lie between two and the depth minus two, inclusive. An illegal request is dropped and sets a sticky error bit, which only reset clears. The memory array, the pointers themselves and the write side belong to the surrounding FIFO.

Top module: `fifo_rewind_ctrl`

## Requirements
- R1: While reset (`rst_n` low) is applied and in the first cycle after it, `setup_busy`, `rptr_reload`, `ef_force_low`, `flag_invalid` and `rt_err` are all 0.
- R2: A request is a rising `clk_rd` edge that samples `rt_n` low after the previous edge sampled it high. An accepted request makes `setup_busy` 1 from that edge on for exactly SETUP_CYC cycles (default 2). It then returns to 0.
- R3: `ef_force_low` and `flag_invalid` are 1 in exactly the cycles where `setup_busy` is 1.
- R4: `rptr_reload` is 1 for one cycle only: the first cycle of each setup phase.
- R5: With `zero_lat` = 0, a request that samples `ren_n` low is ignored (no setup) and sets `rt_err`.
- R6: In either mode, a request that samples `wen_n` low is ignored and sets `rt_err`.
- R7: With `zero_lat` = 1, a request is accepted whether `ren_n` is low or high, provided R6 and R8 allow it.
- R8: The read count is the number of edges that sampled `ren_n` low since reset, saturating at DEPTH. It is taken before the request edge. A request is ignored and sets `rt_err` unless 2 <= count <= DEPTH-2.
- R9: Holding `rt_n` low does not start another setup. A new falling request that arrives while setup is running is ignored and does not set `rt_err`.
- R10: Once set, `rt_err` stays 1 until reset, and accepted requests do not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_rd | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rt_n | input | 1 | Active-low retransmit request |
| ren_n | input | 1 | Active-low read enable |
| wen_n | input | 1 | Active-low write enable |
| zero_lat | input | 1 | 1 selects zero-latency mode, 0 selects normal-latency mode |
| rptr_reload | output | 1 | One-cycle pulse that loads the read pointer with location zero |
| ef_force_low | output | 1 | Holds the FIFO empty flag low during setup |
| setup_busy | output | 1 | Setup phase in progress |
| flag_invalid | output | 1 | Almost-empty and almost-full flags are not valid |
| rt_err | output | 1 | Sticky flag for a rejected request |

## Verification
Two functions can fall on the same edge: counting a read and judging a retransmit request. In zero-latency mode a request may arrive with `ren_n` low, so that edge both counts a read and tests the count. The sweep provokes this for every read count from zero to past saturation. It expects the decision to use the count from before the edge, so a count of one is rejected even though the same edge brings it to two. A second collision is a fresh falling request that lands inside a running setup. The bench judges it by checking that the busy window keeps its length, that no second reload pulse appears and that the error bit stays clear.

// File: rtl/rw_pkg.sv
package rw_pkg;
    typedef enum logic {
        RW_IDLE  = 1'b0,
        RW_SETUP = 1'b1
    } rw_state_e;
endpackage

// File: rtl/rw_readcount.sv
module rw_readcount #(
    parameter int DEPTH = 8,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk_rd,
    input  logic          rst_n,
    input  logic          ren_n,
    output logic [CW-1:0] rd_cnt
);
    localparam logic [CW-1:0] CNT_MAX = CW'(DEPTH);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!ren_n && cnt_q != CNT_MAX) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk_rd or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign rd_cnt = cnt_q;
endmodule

// File: rtl/rw_gate.sv
module rw_gate #(
    parameter int DEPTH = 8,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic [CW-1:0] rd_cnt,
    input  logic          ren_n,
    input  logic          wen_n,
    input  logic          zero_lat,
    output logic          legal
);
    localparam logic [CW-1:0] CNT_LO = CW'(2);
    localparam logic [CW-1:0] CNT_HI = CW'(DEPTH - 2);

    logic cnt_ok;
    logic ren_ok;

    always_comb begin
        cnt_ok = (rd_cnt >= CNT_LO) && (rd_cnt <= CNT_HI);
        ren_ok = zero_lat || ren_n;
        legal  = cnt_ok && ren_ok && wen_n;
    end
endmodule

// File: rtl/rw_seq.sv
module rw_seq #(
    parameter int SETUP_CYC = 2,
    parameter int SW        = (SETUP_CYC > 1) ? $clog2(SETUP_CYC) : 1
) (
    input  logic clk_rd,
    input  logic rst_n,
    input  logic rt_n,
    input  logic legal,
    output logic busy,
    output logic reload,
    output logic err
);
    import rw_pkg::*;

    localparam logic [SW-1:0] TMR_LOAD = SW'(SETUP_CYC - 1);

    typedef struct packed {
        rw_state_e     state;
        logic [SW-1:0] tmr;
        logic          rt_prev;
        logic          reload;
        logic          err;
    } seq_t;

    seq_t s_d, s_q;
    logic req;

    always_comb begin
        s_d         = s_q;
        s_d.rt_prev = rt_n;
        s_d.reload  = 1'b0;
        req         = s_q.rt_prev && !rt_n;
        unique case (s_q.state)
            RW_IDLE: begin
                if (req) begin
                    if (legal) begin
                        s_d.state  = RW_SETUP;
                        s_d.tmr    = TMR_LOAD;
                        s_d.reload = 1'b1;
                    end else begin
                        s_d.err = 1'b1;
                    end
                end
            end
            RW_SETUP: begin
                if (s_q.tmr == '0) s_d.state = RW_IDLE;
                else               s_d.tmr   = s_q.tmr - 1'b1;
            end
            default: s_d.state = RW_IDLE;
        endcase
    end

    always_ff @(posedge clk_rd or negedge rst_n) begin
        if (!rst_n) begin
            s_q.state   <= RW_IDLE;
            s_q.tmr     <= '0;
            s_q.rt_prev <= 1'b1;
            s_q.reload  <= 1'b0;
            s_q.err     <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy   = (s_q.state == RW_SETUP);
    assign reload = s_q.reload;
    assign err    = s_q.err;
endmodule

// File: rtl/fifo_rewind_ctrl.sv
module fifo_rewind_ctrl #(
    parameter int DEPTH     = 8,
    parameter int SETUP_CYC = 2
) (
    input  logic clk_rd,
    input  logic rst_n,
    input  logic rt_n,
    input  logic ren_n,
    input  logic wen_n,
    input  logic zero_lat,
    output logic rptr_reload,
    output logic ef_force_low,
    output logic setup_busy,
    output logic flag_invalid,
    output logic rt_err
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [CW-1:0] rd_cnt;
    logic          legal;
    logic          busy;

    rw_readcount #(.DEPTH(DEPTH), .CW(CW)) u_cnt (
        .clk_rd (clk_rd),
        .rst_n  (rst_n),
        .ren_n  (ren_n),
        .rd_cnt (rd_cnt)
    );

    rw_gate #(.DEPTH(DEPTH), .CW(CW)) u_gate (
        .rd_cnt   (rd_cnt),
        .ren_n    (ren_n),
        .wen_n    (wen_n),
        .zero_lat (zero_lat),
        .legal    (legal)
    );

    rw_seq #(.SETUP_CYC(SETUP_CYC)) u_seq (
        .clk_rd (clk_rd),
        .rst_n  (rst_n),
        .rt_n   (rt_n),
        .legal  (legal),
        .busy   (busy),
        .reload (rptr_reload),
        .err    (rt_err)
    );

    assign setup_busy   = busy;
    assign ef_force_low = busy;
    assign flag_invalid = busy;
endmodule

// File: rtl/fifo_rewind_ctrl_chk.sv
module fifo_rewind_ctrl_chk #(
    parameter int SETUP_CYC = 2
) (
    input logic clk_rd,
    input logic rst_n,
    input logic ren_n,
    input logic wen_n,
    input logic zero_lat,
    input logic rptr_reload,
    input logic ef_force_low,
    input logic setup_busy,
    input logic flag_invalid,
    input logic rt_err
);
    logic [7:0] run_q;

    always_ff @(posedge clk_rd or negedge rst_n) begin
        if (!rst_n)          run_q <= '0;
        else if (setup_busy) run_q <= run_q + 8'd1;
        else                 run_q <= '0;
    end

    // R1
    always @(posedge clk_rd) begin
        if (!rst_n) begin
            reset_quiet_chk: assert (!setup_busy && !rptr_reload && !rt_err);
        end
    end

    // R2
    setup_len_chk: assert property (@(posedge clk_rd) disable iff (!rst_n)
        $fell(setup_busy) |-> (run_q == 8'(SETUP_CYC)));

    // R3
    flags_follow_chk: assert property (@(posedge clk_rd) disable iff (!rst_n)
        setup_busy |-> (ef_force_low && flag_invalid));

    // R4
    reload_single_chk: assert property (@(posedge clk_rd) disable iff (!rst_n)
        rptr_reload |=> !rptr_reload);

    // R4
    reload_at_start_chk: assert property (@(posedge clk_rd) disable iff (!rst_n)
        $rose(setup_busy) |-> rptr_reload);

    // R5
    normal_ren_chk: assert property (@(posedge clk_rd) disable iff (!rst_n)
        ($rose(setup_busy) && !$past(zero_lat)) |-> $past(ren_n));

    // R6
    wen_idle_chk: assert property (@(posedge clk_rd) disable iff (!rst_n)
        $rose(setup_busy) |-> $past(wen_n));

    // R10
    err_sticky_chk: assert property (@(posedge clk_rd) disable iff (!rst_n)
        rt_err |=> rt_err);
endmodule

bind fifo_rewind_ctrl fifo_rewind_ctrl_chk #(.SETUP_CYC(SETUP_CYC)) u_chk (
    .clk_rd       (clk_rd),
    .rst_n        (rst_n),
    .ren_n        (ren_n),
    .wen_n        (wen_n),
    .zero_lat     (zero_lat),
    .rptr_reload  (rptr_reload),
    .ef_force_low (ef_force_low),
    .setup_busy   (setup_busy),
    .flag_invalid (flag_invalid),
    .rt_err       (rt_err)
);

// File: tb/sim_fifo_rewind_ctrl.sv
`timescale 1ns/1ps
module sim_fifo_rewind_ctrl;
    localparam int DEPTH = 8;
    localparam int SETUP_CYC = 2;

    logic clk_rd = 1'b0;
    logic rst_n = 1'b0;
    logic rt_n = 1'b1;
    logic ren_n = 1'b1;
    logic wen_n = 1'b1;
    logic zero_lat = 1'b0;
    logic rptr_reload, ef_force_low, setup_busy, flag_invalid, rt_err;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk_rd = ~clk_rd;

    fifo_rewind_ctrl #(.DEPTH(DEPTH), .SETUP_CYC(SETUP_CYC)) u0 (
        .clk_rd(clk_rd), .rst_n(rst_n), .rt_n(rt_n), .ren_n(ren_n),
        .wen_n(wen_n), .zero_lat(zero_lat), .rptr_reload(rptr_reload),
        .ef_force_low(ef_force_low), .setup_busy(setup_busy),
        .flag_invalid(flag_invalid), .rt_err(rt_err)
    );

    task automatic tick();
        @(posedge clk_rd);
        #1;
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; rt_n = 1'b1; ren_n = 1'b1; wen_n = 1'b1;
        tick(); tick();
        rst_n = 1'b1;
        tick();
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        do_reset();
        chk({setup_busy, rptr_reload, ef_force_low, flag_invalid, rt_err} == 5'b0,
            "R1 reset outputs", {setup_busy, rptr_reload, ef_force_low, flag_invalid, rt_err}, 0);

        // Sweep: read count x mode x ren x wen
        for (int n = 0; n <= DEPTH + 1; n++) begin
            for (int m = 0; m < 2; m++) begin
                for (int r = 0; r < 2; r++) begin
                    for (int w = 0; w < 2; w++) begin
                        int  cnt;
                        bit  acc;
                        do_reset();
                        for (int k = 0; k < n; k++) begin
                            ren_n = 1'b0; tick();
                        end
                        ren_n = 1'b1;
                        cnt = (n > DEPTH) ? DEPTH : n;
                        // R5 R6 R7 R8: acceptance rule
                        acc = (cnt >= 2) && (cnt <= DEPTH - 2) && (w == 1) && ((m == 1) || (r == 1));
                        zero_lat = m[0]; ren_n = r[0]; wen_n = w[0]; rt_n = 1'b0;
                        tick();
                        chk(setup_busy == acc, "R2 R5 R6 R7 R8 accept", setup_busy, acc);
                        chk(rt_err == !acc, "R5 R6 R8 err on reject", rt_err, !acc);
                        chk(rptr_reload == acc, "R4 reload first cycle", rptr_reload, acc);
                        chk(ef_force_low == acc && flag_invalid == acc, "R3 flags in setup",
                            {ef_force_low, flag_invalid}, {acc, acc});
                        ren_n = 1'b1; wen_n = 1'b1;
                        tick();
                        chk(setup_busy == acc, "R2 second setup cycle", setup_busy, acc);
                        chk(rptr_reload == 1'b0, "R4 reload single", rptr_reload, 0);
                        tick();
                        chk(setup_busy == 1'b0, "R2 R9 setup ends while held", setup_busy, 0);
                        chk(ef_force_low == 1'b0 && flag_invalid == 1'b0, "R3 flags released",
                            {ef_force_low, flag_invalid}, 0);
                        tick();
                        chk(setup_busy == 1'b0 && rptr_reload == 1'b0, "R9 no retrigger",
                            setup_busy, 0);
                        chk(rt_err == !acc, "R10 err sticky", rt_err, !acc);
                        rt_n = 1'b1;
                        tick();
                    end
                end
            end
        end

        // R9: new falling request during setup, zero-latency with ren low
        do_reset();
        for (int k = 0; k < 3; k++) begin
            ren_n = 1'b0; tick();
        end
        zero_lat = 1'b1; ren_n = 1'b0; rt_n = 1'b0;
        tick();
        chk(setup_busy == 1'b1, "R7 zero-latency accept with read", setup_busy, 1);
        rt_n = 1'b1; ren_n = 1'b1;
        tick();
        chk(setup_busy == 1'b1, "R2 busy cycle two", setup_busy, 1);
        rt_n = 1'b0;
        tick();
        chk(setup_busy == 1'b0 && rptr_reload == 1'b0, "R9 request in setup ignored",
            {setup_busy, rptr_reload}, 0);
        chk(rt_err == 1'b0, "R9 no err for request in setup", rt_err, 0);
        rt_n = 1'b1;
        tick();

        // R10: error survives an accepted request
        do_reset();
        zero_lat = 1'b0;
        rt_n = 1'b0; tick();
        chk(rt_err == 1'b1, "R8 early request rejected", rt_err, 1);
        rt_n = 1'b1;
        for (int k = 0; k < 4; k++) begin
            ren_n = 1'b0; tick();
        end
        ren_n = 1'b1;
        rt_n = 1'b0; tick();
        chk(setup_busy == 1'b1, "R2 later accept", setup_busy, 1);
        chk(rt_err == 1'b1, "R10 err kept after accept", rt_err, 1);
        rt_n = 1'b1;
        tick(); tick();
        do_reset();
        chk(rt_err == 1'b0, "R10 err cleared by reset", rt_err, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule